// File: doc/BRIEF.md
# Cascaded Two-Bank Deep RAM

This block builds a single-bit-wide memory of twice the depth of one bank by chaining two identical banks. Both banks see the same low word address, the same top address bit, the same data bit and the same write strobe. A role parameter makes one bank the lower half and the other the upper half. The lower bank hands its read bit to the upper bank over a dedicated cascade link. The upper bank then drives the block output, using its own bit or the cascaded one according to the top address bit. No decode or multiplexing logic sits outside the banks.

Reads are synchronous and happen on every clock edge. An optional output register adds one stage to each bank. The select bit is carried through the same stages, so data and select stay aligned. The memory accepts one operation per cycle and has no back-pressure: there is no valid/ready pair, and a result appears on `dout` a fixed number of cycles after its address. Each bank's depth is set by `BANK_AW`. A full-size build uses 15, which gives two 32K x 1 banks and a 64K x 1 result. The default is smaller, to keep elaboration light.

Top module: `cascaded_deep_ram`

## Requirements
- R1: A write with the top address bit at 0 updates only the lower bank. The upper-half word at the same low address keeps its value.
- R2: A write with the top address bit at 1 updates only the upper bank. The lower-half word at the same low address keeps its value.
- R3: Read data for the address presented at a clock edge appears on `dout` after 1 edge when `OUT_REG` is 0, and after 2 edges when `OUT_REG` is 1. Back-to-back reads return one result per cycle.
- R4: `dout` shows the upper bank's word when the delayed top address bit is 1. When that bit is 0, it shows the lower bank's word as carried over the cascade link. The whole address space of 2·2^BANK_AW words is distinct.
- R5: A read of the address being written in the same cycle returns the old content. The new content is seen from the next read on.
- R6: While `rst_n` is low, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read pipeline |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | BANK_AW+1 | Word address; the top bit picks the upper (1) or lower (0) bank |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit, 1 or 2 cycles after its address |

## Verification
The assertions assume that the block starts in reset and that `addr`, `wr_en` and `din` are known on every edge after reset. Latency and select checks are gated by a count of edges since reset, so they never reach back into reset. The stimulus changes the inputs just after the falling edge, holds them over the rising edge, and issues an operation on every cycle. Both the plain build and the registered build receive the same stream, and each is compared with a model that records the value to expect before the write of that same cycle takes effect.

// File: rtl/deep_ram_pkg.sv
package deep_ram_pkg;
  typedef enum logic {
    ROLE_LOWER = 1'b0,
    ROLE_UPPER = 1'b1
  } bank_role_e;
endpackage

// File: rtl/cas_bank.sv
module cas_bank
  import deep_ram_pkg::*;
#(
  parameter bank_role_e ROLE    = ROLE_LOWER,
  parameter int         AW      = 10,
  parameter bit         OUT_REG = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic [AW-1:0] addr,
  input  logic          addr_hi,
  input  logic          we,
  input  logic          cas_in,
  output logic          dout,
  output logic          cas_out
);
  localparam int   DEPTH    = 1 << AW;
  localparam int   LAT      = OUT_REG ? 2 : 1;
  localparam logic ROLE_BIT = (ROLE == ROLE_UPPER);

  logic mem [DEPTH];
  logic wr_hit;
  logic rd_q, sel_q;
  logic stage_d, stage_sel;
  logic [1:0] warm;

  // A bank takes a write only when the top address bit names its half.
  assign wr_hit = we && (addr_hi == ROLE_BIT);

  always_ff @(posedge clk) begin
    if (wr_hit) mem[addr] <= din;
  end

  // Read-first: the array word is sampled before this edge's write lands.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      rd_q  <= mem[addr];
      sel_q <= addr_hi;
    end
  end

  generate
    if (OUT_REG) begin : g_oreg
      logic rd_o, sel_o;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rd_o  <= 1'b0;
          sel_o <= 1'b0;
        end else begin
          rd_o  <= rd_q;
          sel_o <= sel_q;
        end
      end
      assign stage_d   = rd_o;
      assign stage_sel = sel_o;
    end else begin : g_direct
      assign stage_d   = rd_q;
      assign stage_sel = sel_q;
    end
  endgenerate

  assign cas_out = stage_d;
  assign dout    = (stage_sel == ROLE_BIT) ? stage_d : cas_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm <= 2'd0;
    else if (warm != 2'd3)  warm <= warm + 2'd1;
  end

  AST_WR_STEER: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr_hi != ROLE_BIT) |=> mem[$past(addr)] == $past(mem[addr])); // R1 R2

  AST_SEL_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'(LAT)) |-> stage_sel == $past(addr_hi, LAT)); // R3
endmodule

// File: rtl/cascaded_deep_ram.sv
module cascaded_deep_ram
  import deep_ram_pkg::*;
#(
  parameter int BANK_AW = 10,
  parameter bit OUT_REG = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BANK_AW:0] addr,
  input  logic             din,
  output logic             dout
);
  localparam int LAT = OUT_REG ? 2 : 1;

  logic lower_cas, lower_dout, upper_cas;
  logic [1:0] warm;

  cas_bank #(.ROLE(ROLE_LOWER), .AW(BANK_AW), .OUT_REG(OUT_REG)) u_lower (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din),
    .addr    (addr[BANK_AW-1:0]),
    .addr_hi (addr[BANK_AW]),
    .we      (wr_en),
    .cas_in  (1'b0),
    .dout    (lower_dout),
    .cas_out (lower_cas)
  );

  cas_bank #(.ROLE(ROLE_UPPER), .AW(BANK_AW), .OUT_REG(OUT_REG)) u_upper (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din),
    .addr    (addr[BANK_AW-1:0]),
    .addr_hi (addr[BANK_AW]),
    .we      (wr_en),
    .cas_in  (lower_cas),
    .dout    (dout),
    .cas_out (upper_cas)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  always_comb begin
    if (!rst_n) AST_RST_ZERO: assert (dout == 1'b0); // R6
  end

  AST_OUT_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'(LAT) && $past(addr[BANK_AW], LAT) == 1'b0)
      |-> (dout == lower_cas && lower_dout == lower_cas)); // R4

  AST_OUT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'(LAT) && $past(addr[BANK_AW], LAT) == 1'b1)
      |-> dout == upper_cas); // R4
endmodule

// File: tb/test_cascaded_deep_ram.sv
module test_cascaded_deep_ram;
  localparam int AW    = 6;
  localparam int WORDS = 2 << AW;
  localparam int HALF  = 1 << AW;

  typedef struct packed {
    bit chk;
    bit val;
    int req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW:0] addr = '0;
  logic din = 1'b0;
  logic dout0, dout1;

  int checks = 0;
  int errors = 0;
  bit run = 1'b0;
  bit done = 1'b0;

  bit shadow [WORDS];
  bit known  [WORDS];
  item_t q0 [$];
  item_t q1 [$];

  always #2.5 clk = ~clk;

  cascaded_deep_ram #(.BANK_AW(AW), .OUT_REG(1'b0)) i_cascaded_deep_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .din(din), .dout(dout0));

  cascaded_deep_ram #(.BANK_AW(AW), .OUT_REG(1'b1)) i_cascaded_deep_ram_p (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .din(din), .dout(dout1));

  // Driver: one operation per cycle; expected value is the pre-write content (R5).
  task automatic op(input bit w, input int a, input bit d, input int req);
    item_t it;
    @(negedge clk);
    #1;
    wr_en = w;
    addr  = (AW+1)'(a);
    din   = d;
    it.chk = known[a];
    it.val = shadow[a];
    it.req = req;
    q0.push_back(it);
    q1.push_back(it);
    if (w) begin
      shadow[a] = d;
      known[a]  = 1'b1;
    end
  endtask

  // Monitor: latency 1 for the plain build, 2 for the registered build (R3).
  always @(negedge clk) begin
    if (run) begin
      if (q0.size() >= 1) begin
        item_t it;
        it = q0.pop_front();
        if (it.chk) begin
          checks++;
          if (dout0 !== it.val) begin
            errors++;
            $display("FAIL R%0d plain: dout=%b expected=%b", it.req, dout0, it.val);
          end
        end
      end
      if (q1.size() >= 2) begin
        item_t it;
        it = q1.pop_front();
        if (it.chk) begin
          checks++;
          if (dout1 !== it.val) begin
            errors++;
            $display("FAIL R%0d registered: dout=%b expected=%b", it.req, dout1, it.val);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6: output held at 0 during reset
    checks++;
    if (dout0 !== 1'b0 || dout1 !== 1'b0) begin
      errors++;
      $display("FAIL R6 reset: dout=%b/%b expected=0/0", dout0, dout1);
    end
    @(negedge clk);
    rst_n = 1'b1;
    run   = 1'b1;

    // Fill both halves with complementary patterns (R1, R2)
    for (int a = 0; a < HALF; a++) begin
      op(1'b1, a,        1'(a ^ (a >> 2)), 1);
      op(1'b1, a + HALF, ~1'(a ^ (a >> 2)), 2);
    end
    // Read back the whole space in order (R4)
    for (int a = 0; a < WORDS; a++) op(1'b0, a, 1'b0, 4);
    // Alternate halves on every cycle to stress select alignment (R3, R4)
    for (int a = 0; a < HALF; a++) begin
      op(1'b0, a + HALF, 1'b0, 3);
      op(1'b0, a,        1'b0, 3);
    end
    // R1: lower write leaves upper word intact
    for (int a = 0; a < HALF; a += 3) begin
      op(1'b1, a, ~shadow[a], 1);
      op(1'b0, a + HALF, 1'b0, 1);
      op(1'b0, a,        1'b0, 1);
    end
    // R2: upper write leaves lower word intact
    for (int a = 1; a < HALF; a += 3) begin
      op(1'b1, a + HALF, ~shadow[a + HALF], 2);
      op(1'b0, a,        1'b0, 2);
      op(1'b0, a + HALF, 1'b0, 2);
    end
    // R5: read during write returns the old bit, then the new one
    for (int a = 0; a < WORDS; a += 5) begin
      op(1'b1, a, ~shadow[a], 5);
      op(1'b0, a, 1'b0, 5);
    end
    // Back-to-back writes to one word, each read-first (R5)
    op(1'b1, 7, 1'b1, 5);
    op(1'b1, 7, 1'b0, 5);
    op(1'b1, 7, 1'b1, 5);
    op(1'b0, 7, 1'b0, 5);
    // Drain the pipelines
    for (int i = 0; i < 4; i++) begin
      op(1'b0, 0, 1'b0, 3);
      q0[q0.size()-1].chk = 1'b0;
      q1[q1.size()-1].chk = 1'b0;
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule